// File: doc/BRIEF.md
# Fractional-N Feedback Modulus Controller

This block chooses, for each divided reference cycle of a fractional-N synthesizer, whether the feedback divider counts with the integer value F or with F+1. A programmable period of p reference cycles is divided so that exactly f of them use F+1 and the rest use F. The average feedback divide is then F + f/p, and the synthesizer's effective multiplier becomes (F+1+f/p)/2 where the integer mode gives (F+1)/2. The F+1 cycles are placed by a first-order accumulator that adds f on every cycle and wraps at p. This spreads the extra counts evenly across the period rather than bunching them together. Keeping p small shortens the repeat pattern and lowers the jitter it causes.

A host writes one control word that carries an enable flag, the fraction numerator f and the period p. A word with f not below p is refused and raises an error flag. An accepted word is staged and only becomes active at the next period boundary, so a period in progress always runs to completion under the settings it started with. The divider logic pulses `ref_tick` once per divided reference cycle. It reads `div_value` as the modulus for the coming cycle and uses `period_start` to see where each period begins.

Top module: `fracn_modulus_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `div_value` is 0, `period_start` is 0 and `cfg_err` is 0. The active configuration starts disabled and no word is staged.
- R2: The control word uses bit 31 as the enable flag, bits 15:8 as f and bits 7:0 as p, so 0x80000B19 means enabled with f=11 and p=25. A write with f < p is accepted as the staged configuration and drives `cfg_err` to 0 on the next cycle.
- R3: A write with f >= p (this includes f=0 with p=0) is discarded. `cfg_err` is 1 from the next cycle and stays set until a later write is accepted. The staged and active configurations are left unchanged.
- R4: A staged word becomes active on the first `ref_tick` after the write cycle at which the phase index is 0. That is the first tick after reset, any tick in integer mode, or the tick that follows the last of the p ticks of a fractional period.
- R5: In fractional mode (enable set and f > 0), an accumulator starts at 0 at each period boundary. On each tick it adds f, and when the sum reaches p or more it subtracts p and that tick selects F+1. Each period of p ticks therefore gives exactly f ticks of F+1.
- R6: When the active enable is 0 or f is 0, every tick selects F, and every tick is flagged as a period start.
- R7: `div_value` and `period_start` are registered and update in the cycle after the tick. `div_value` holds its value between ticks. `period_start` is high for exactly one cycle after each tick that begins a period, and is low otherwise.
- R8: `div_value` equals the `int_div` sampled at the tick, plus 1 when that tick selects the extra count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One pulse per divided reference cycle |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 32 | Control word: enable bit 31, f 15:8, p 7:0 |
| int_div | input | 13 | Integer feedback value F |
| div_value | output | 14 | Feedback divide value for the current cycle (F or F+1) |
| period_start | output | 1 | One-cycle flag for the first cycle of a period |
| cfg_err | output | 1 | Last write was rejected because f >= p |

## Verification
The bench builds the block with its default widths: a 13-bit F, so F values near 8191 make F+1 carry into bit 13, and 8-bit f and p fields, so a period as long as 255 ticks with f=254 can be run through completely. At these widths the bench can reach the longest period, the densest fraction and the full range of the output value. It also reaches the cases where a write lands in the same cycle as a boundary tick, where ticks arrive back to back, and where F changes part-way through a period.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned CTRL_W_DEF = 32;
  localparam int unsigned FRAC_W_DEF = 8;
  localparam int unsigned F_W_DEF    = 13;

  typedef enum logic {
    DSEL_BASE  = 1'b0,
    DSEL_PLUS1 = 1'b1
  } dsel_e;
endpackage

// File: rtl/fracn_cfg_reg.sv
module fracn_cfg_reg #(
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned EN_POS = 31,
  parameter int unsigned F_LSB  = 8,
  parameter int unsigned P_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              commit,
  output logic              cur_en,
  output logic [FRAC_W-1:0] cur_f,
  output logic [FRAC_W-1:0] cur_p,
  output logic              err
);
  logic              wr_en;
  logic [FRAC_W-1:0] wr_f;
  logic [FRAC_W-1:0] wr_p;
  logic              wr_ok;

  logic              stg_v;
  logic              stg_en;
  logic [FRAC_W-1:0] stg_f;
  logic [FRAC_W-1:0] stg_p;
  logic              act_en;
  logic [FRAC_W-1:0] act_f;
  logic [FRAC_W-1:0] act_p;
  logic              err_q;

  assign wr_en = wdata[EN_POS];
  assign wr_f  = wdata[F_LSB +: FRAC_W];
  assign wr_p  = wdata[P_LSB +: FRAC_W];
  assign wr_ok = (wr_f < wr_p);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v  <= 1'b0;
      stg_en <= 1'b0;
      stg_f  <= '0;
      stg_p  <= '0;
      act_en <= 1'b0;
      act_f  <= '0;
      act_p  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (commit && stg_v) begin
        act_en <= stg_en;
        act_f  <= stg_f;
        act_p  <= stg_p;
        stg_v  <= 1'b0;
      end
      if (wr) begin
        if (wr_ok) begin
          stg_v  <= 1'b1;
          stg_en <= wr_en;
          stg_f  <= wr_f;
          stg_p  <= wr_p;
          err_q  <= 1'b0;
        end else begin
          err_q  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (commit && stg_v) begin
      cur_en = stg_en;
      cur_f  = stg_f;
      cur_p  = stg_p;
    end else begin
      cur_en = act_en;
      cur_f  = act_f;
      cur_p  = act_p;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic [FRAC_W-1:0] f,
  input  logic [FRAC_W-1:0] p,
  output logic              at_boundary,
  output logic              hit,
  output logic              first
);
  localparam int unsigned SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] idx_q;
  logic [FRAC_W-1:0] acc_base;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  sum_wrap;
  logic              frac_on;
  logic              last_idx;

  assign at_boundary = (idx_q == '0);
  assign frac_on     = en && (f != '0);
  assign acc_base    = at_boundary ? '0 : acc_q;
  assign sum         = {1'b0, acc_base} + {1'b0, f};
  assign hit         = frac_on && (sum >= {1'b0, p});
  assign sum_wrap    = hit ? (sum - {1'b0, p}) : sum;
  assign last_idx    = ({1'b0, idx_q} + 1'b1) >= {1'b0, p};
  assign first       = frac_on ? at_boundary : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (tick) begin
      if (frac_on) begin
        acc_q <= sum_wrap[FRAC_W-1:0];
        idx_q <= last_idx ? '0 : idx_q + 1'b1;
      end else begin
        acc_q <= '0;
        idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/fracn_div_out.sv
module fracn_div_out
  import fracn_pkg::*;
#(
  parameter int unsigned F_W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         hit,
  input  logic         first,
  input  logic [F_W-1:0] int_div,
  output logic [F_W:0] div_value,
  output logic         period_start
);
  dsel_e sel;

  assign sel = hit ? DSEL_PLUS1 : DSEL_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_value    <= '0;
      period_start <= 1'b0;
    end else begin
      period_start <= tick && first;
      if (tick) begin
        if (sel == DSEL_PLUS1) div_value <= {1'b0, int_div} + 1'b1;
        else                   div_value <= {1'b0, int_div};
      end
    end
  end
endmodule

// File: rtl/fracn_modulus_ctrl.sv
module fracn_modulus_ctrl #(
  parameter int unsigned CTRL_W = fracn_pkg::CTRL_W_DEF,
  parameter int unsigned FRAC_W = fracn_pkg::FRAC_W_DEF,
  parameter int unsigned F_W    = fracn_pkg::F_W_DEF,
  parameter int unsigned EN_POS = 31,
  parameter int unsigned F_LSB  = 8,
  parameter int unsigned P_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_data,
  input  logic [F_W-1:0]    int_div,
  output logic [F_W:0]      div_value,
  output logic              period_start,
  output logic              cfg_err
);
  logic              cur_en;
  logic [FRAC_W-1:0] cur_f;
  logic [FRAC_W-1:0] cur_p;
  logic              at_boundary;
  logic              hit;
  logic              first;
  logic              commit;

  assign commit = ref_tick && at_boundary;

  fracn_cfg_reg #(
    .CTRL_W(CTRL_W), .FRAC_W(FRAC_W), .EN_POS(EN_POS), .F_LSB(F_LSB), .P_LSB(P_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_data), .commit(commit),
    .cur_en(cur_en), .cur_f(cur_f), .cur_p(cur_p), .err(cfg_err)
  );

  fracn_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .tick(ref_tick), .en(cur_en), .f(cur_f), .p(cur_p),
    .at_boundary(at_boundary), .hit(hit), .first(first)
  );

  fracn_div_out #(.F_W(F_W)) u_out (
    .clk(clk), .rst(rst), .tick(ref_tick), .hit(hit), .first(first),
    .int_div(int_div), .div_value(div_value), .period_start(period_start)
  );
endmodule

// File: rtl/fracn_modulus_ctrl_chk.sv
module fracn_modulus_ctrl_chk #(
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned F_W    = 13,
  parameter int unsigned F_LSB  = 8,
  parameter int unsigned P_LSB  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_tick,
  input logic              cfg_wr,
  input logic [CTRL_W-1:0] cfg_data,
  input logic [F_W-1:0]    int_div,
  input logic [F_W:0]      div_value,
  input logic              period_start,
  input logic              cfg_err
);
  logic bad_word;
  assign bad_word = cfg_data[F_LSB +: FRAC_W] >= cfg_data[P_LSB +: FRAC_W];

  // R8: output is F or F+1 of the F seen at the tick
  assert_div_range_R8: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> ((div_value == {1'b0, $past(int_div)}) ||
                  (div_value == {1'b0, $past(int_div)} + 1'b1)));

  // R7: value held when no tick
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(div_value));

  // R7: period flag only follows a tick
  assert_ps_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
    period_start |-> $past(ref_tick));

  // R3: refused word raises the error flag
  assert_bad_word_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && bad_word) |=> cfg_err);

  // R2: accepted word clears the error flag
  assert_good_word_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !bad_word) |=> !cfg_err);
endmodule

bind fracn_modulus_ctrl fracn_modulus_ctrl_chk #(
  .CTRL_W(CTRL_W), .FRAC_W(FRAC_W), .F_W(F_W), .F_LSB(F_LSB), .P_LSB(P_LSB)
) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
  .int_div(int_div), .div_value(div_value), .period_start(period_start), .cfg_err(cfg_err)
);

// File: tb/fracn_modulus_ctrl_tb.sv
module fracn_modulus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_data = '0;
  logic [12:0] int_div = '0;
  logic [13:0] div_value;
  logic        period_start;
  logic        cfg_err;

  always #10 clk = ~clk;

  fracn_modulus_ctrl u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .int_div(int_div), .div_value(div_value), .period_start(period_start), .cfg_err(cfg_err)
  );

  int vecs = 0;
  int fails = 0;
  string req = "R1";

  // behavioural reference state
  int m_act_en = 0, m_act_f = 0, m_act_p = 0;
  int m_stg = 0, m_stg_en = 0, m_stg_f = 0, m_stg_p = 0;
  int m_idx = 0, m_acc = 0;
  int e_div = 0, e_ps = 0, e_err = 0;

  task automatic compare();
    vecs++;
    if (int'(div_value) != e_div) begin
      fails++;
      $display("FAIL %s div_value actual=%0d expected=%0d t=%0t", req, div_value, e_div, $time);
    end
    if (int'(period_start) != e_ps) begin
      fails++;
      $display("FAIL R7 period_start actual=%0d expected=%0d t=%0t", period_start, e_ps, $time);
    end
    if (int'(cfg_err) != e_err) begin
      fails++;
      $display("FAIL R3 cfg_err actual=%0d expected=%0d t=%0t", cfg_err, e_err, $time);
    end
  endtask

  task automatic model_step(input bit r, input bit t, input bit w, input logic [31:0] d, input int fv);
    if (r) begin
      m_act_en = 0; m_act_f = 0; m_act_p = 0; m_stg = 0;
      m_idx = 0; m_acc = 0; e_div = 0; e_ps = 0; e_err = 0;
      return;
    end
    if (t) begin
      if (m_idx == 0 && m_stg != 0) begin
        m_act_en = m_stg_en; m_act_f = m_stg_f; m_act_p = m_stg_p;
        m_stg = 0; m_acc = 0;
      end
      if (m_act_en != 0 && m_act_f != 0) begin
        bit extra;
        e_ps = (m_idx == 0);
        m_acc = m_acc + m_act_f;
        extra = (m_acc >= m_act_p);
        if (extra) m_acc = m_acc - m_act_p;
        e_div = fv + int'(extra);
        m_idx = (m_idx + 1) % m_act_p;
      end else begin
        e_ps = 1; e_div = fv; m_idx = 0; m_acc = 0;
      end
    end else begin
      e_ps = 0;
    end
    if (w) begin
      int wf, wp;
      wf = int'(d[15:8]); wp = int'(d[7:0]);
      if (wf >= wp) e_err = 1;
      else begin
        m_stg = 1; m_stg_en = int'(d[31]); m_stg_f = wf; m_stg_p = wp; e_err = 0;
      end
    end
  endtask

  // one clock: check outputs, apply inputs, advance model
  task automatic cyc(input bit t, input bit w, input logic [31:0] d, input int fv);
    @(negedge clk);
    compare();
    ref_tick = t; cfg_wr = w; cfg_data = d; int_div = 13'(fv);
    model_step(rst, t, w, d, fv);
  endtask

  task automatic ticks(input int n, input int gap, input int fv);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 32'h0, fv);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 32'h0, fv);
    end
  endtask

  task automatic wr(input logic [31:0] d, input int fv);
    cyc(1'b0, 1'b1, d, fv);
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    model_step(1'b1, 1'b0, 1'b0, 32'h0, 0);
    repeat (3) cyc(1'b0, 1'b0, 32'h0, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) cyc(1'b0, 1'b0, 32'h0, 124);

    // R6: disabled after reset, plain integer divide
    req = "R6";
    ticks(8, 2, 124);

    // R2: word 0x80000B19 means f=11, p=25; R5 over several periods
    req = "R2";
    wr(32'h80000B19, 124);
    req = "R5";
    ticks(80, 1, 124);

    // R4: mid-period write of f=4,p=5 waits for the boundary
    req = "R4";
    ticks(7, 0, 124);
    wr(32'h80000405, 124);
    ticks(30, 1, 124);

    // R3: f>=p refused, behaviour unchanged
    req = "R3";
    wr(32'h80000505, 124);
    ticks(12, 0, 124);
    wr(32'h80000000, 124);
    ticks(6, 1, 124);

    // R6: f=0 with enable, then enable clear with f=3,p=4
    req = "R6";
    wr(32'h80000007, 124);
    ticks(10, 1, 124);
    wr(32'h00000304, 124);
    ticks(10, 0, 124);

    // R8: F changes during a fractional period, top of range
    req = "R8";
    wr(32'h80000102, 8190);
    ticks(6, 1, 8190);
    ticks(6, 0, 8191);
    wr(32'h80000305, 200);
    ticks(12, 2, 200);

    // R4: write in the same cycle as a boundary tick
    req = "R4";
    wr(32'h80000203, 99);
    ticks(2, 0, 99);
    cyc(1'b1, 1'b1, 32'h80000104, 99);
    ticks(20, 0, 99);

    // R5: longest period, densest fraction
    req = "R5";
    wr(32'h8000FEFF, 60);
    ticks(520, 0, 60);

    // R7: irregular tick spacing with changing F
    req = "R7";
    wr(32'h80000B19, 300);
    for (int i = 0; i < 400; i++) begin
      int rv;
      rv = int'($urandom_range(0, 3));
      cyc(rv == 0, 1'b0, 32'h0, 300 + (i / 97));
    end

    // R1: reset again mid-run
    req = "R1";
    @(negedge clk); compare(); rst = 1'b1; ref_tick = 1'b0; cfg_wr = 1'b0;
    model_step(1'b1, 1'b0, 1'b0, 32'h0, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) cyc(1'b0, 1'b0, 32'h0, 5);
    req = "R6";
    ticks(3, 0, 5);
    cyc(1'b0, 1'b0, 32'h0, 5);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule